// File: doc/BRIEF.md
# EDO DRAM Access Cycle Generator

This block sits between a simple synchronous host port and a 16-bit EDO DRAM that has one column strobe for each byte lane. A host request carries the operation, an 18-bit word address, two byte enables and write data. The block splits the address into a row and a column and multiplexes them onto a 9-bit address bus. It then plays out one complete single-access cycle on the row strobe, the two column strobes, the write strobe and the output enable. A read returns the captured word on the host side together with a one-cycle done pulse.

A refresh sequencer outside this block owns the DRAM between accesses, and the generator opens a cycle only while that sequencer grants it. Writes always use early-write ordering: the write strobe is low before any column strobe falls, and the output enable stays high. The DRAM therefore never drives the data pins during a write, and only the host-side driver is active. Read data is sampled at a cycle count fixed at elaboration. That count is the latest of three limits: row-strobe-to-data, column-strobe-to-data and column-address-to-data.

All timing is in clock cycles and set by parameters. Derived points are counted from the cycle in which the row strobe goes low (k = 0):
- The column address appears at k = 1.
- The column strobes fall at k = T_RCD.
- Data is captured at K_CAP = max(T_RAC, T_RCD + T_CAC, 1 + T_AA).
- The column strobes rise at K_CE = max(T_RCD + T_CAS, K_CAP + 1).
- The row strobe rises at K_CE + 1.

Top module: `edo_cycle_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, every strobe (ras_n_o, both cas_n_o bits, we_n_o, oe_n_o) is high, dq_oe_o is low and done_o is low.
- R2: A cycle starts only when the block is idle and req_i and grant_i are both high. The row strobe falls exactly two cycles after that accepting cycle. While grant_i is low no row strobe falls.
- R3: When ras_n_o falls, ma_o carries the row, addr_i[17:9]. When the column strobes fall, ma_o carries the column, addr_i[8:0]. The column strobes fall exactly T_RCD cycles after the row strobe.
- R4: Both column strobes are high in the cycle the row strobe falls. A column strobe is low only while the row strobe is low, and both are high again before the row strobe rises.
- R5: In a write (we_i = 1), we_n_o is low at least one cycle before a column strobe falls and stays low until the column strobes are high again. oe_n_o stays high for the whole write.
- R6: In a read, oe_n_o is low exactly while the column strobes are low, and we_n_o stays high.
- R7: cas_n_o[0] strobes data bits 7:0 and pulses only if be_i[0] is 1. cas_n_o[1] strobes bits 15:8 and pulses only if be_i[1] is 1. A write changes only the enabled bytes.
- R8: Read data is sampled from dq_i on the cycle k = K_CAP. A byte of rdata_o whose enable was 0 reads as zero.
- R9: The column strobes stay low for K_CE - T_RCD cycles, which is at least T_CAS and extends past the capture cycle.
- R10: dq_oe_o is high only in writes, from k = 1 through the cycle the column strobes rise (K_CE), and dq_o carries the request's write data meanwhile.
- R11: done_o is a one-cycle pulse, high in the cycle the row strobe rises, and rdata_o is valid with it. The row strobe stays high at least T_RP cycles before it falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Host request, held until done_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address, row in bits 17:9, column in 8:0 |
| be_i | input | 2 | Byte enables, bit 0 = low byte |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid with done_o |
| done_o | output | 1 | One-cycle completion pulse |
| grant_i | input | 1 | Permission from the refresh sequencer |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 2 | Column strobes, bit 0 low byte, bit 1 high byte, active low |
| we_n_o | output | 1 | Write strobe, active low |
| oe_n_o | output | 1 | Output enable, active low |
| ma_o | output | 9 | Multiplexed row/column address |
| dq_o | output | 16 | Data toward the DRAM |
| dq_oe_o | output | 1 | Enable for the host-side data driver |
| dq_i | input | 16 | Data from the DRAM |

## Verification
Several properties are checked on every cycle: strobe ordering, early-write setup and the output enable staying off during writes, driver enable covering each write strobe, the minimum column-strobe width, the grant precondition and the single-cycle done pulse. Other behaviour only the bench's scenarios can show. This covers exact address multiplexing, the column-strobe delay, per-lane strobing against the byte enables and byte-merged memory contents. It also covers the capture cycle: the bench's memory model drives a poison pattern until all three access limits have elapsed. Finally, the scenarios show the driver window length and that no cycle starts while the grant is withheld.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ROW  = 2'd1,
    PH_ACT  = 2'd2,
    PH_PRE  = 2'd3
  } phase_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/edo_seq_timer.sv
module edo_seq_timer
  import edo_pkg::*;
#(
  parameter int K_RASEND = 7,
  parameter int T_RP     = 2,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output phase_e        phase_q,
  output logic [CW-1:0] cnt_q,
  output phase_e        phase_nxt,
  output logic [CW-1:0] cnt_nxt
);
  localparam logic [CW-1:0] ACT_LAST = CW'(K_RASEND - 1);
  localparam logic [CW-1:0] PRE_LAST = CW'(T_RP - 1);

  always_comb begin
    phase_nxt = phase_q;
    cnt_nxt   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_nxt = PH_ROW;
          cnt_nxt   = '0;
        end
      end
      PH_ROW: begin
        phase_nxt = PH_ACT;
        cnt_nxt   = '0;
      end
      PH_ACT: begin
        if (cnt_q == ACT_LAST) begin
          phase_nxt = PH_PRE;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt_q + CW'(1);
        end
      end
      PH_PRE: begin
        if (cnt_q == PRE_LAST) begin
          phase_nxt = PH_IDLE;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt_q + CW'(1);
        end
      end
      default: begin
        phase_nxt = PH_IDLE;
        cnt_nxt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_nxt;
      cnt_q   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/edo_strobe_dec.sv
module edo_strobe_dec
  import edo_pkg::*;
#(
  parameter int ROW_W    = 9,
  parameter int COL_W    = 9,
  parameter int MA_W     = 9,
  parameter int LANES    = 2,
  parameter int CW       = 4,
  parameter int K_COL    = 1,
  parameter int K_CAS    = 2,
  parameter int K_CASEND = 6
) (
  input  phase_e           phase_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic             we_i,
  input  logic [LANES-1:0] be_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output logic             ras_n,
  output logic [LANES-1:0] cas_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [MA_W-1:0]  ma,
  output logic             dq_oe,
  output logic             done
);
  localparam logic [CW-1:0] C_COL = CW'(K_COL);
  localparam logic [CW-1:0] C_CAS = CW'(K_CAS);
  localparam logic [CW-1:0] C_END = CW'(K_CASEND);

  logic act, col_phase, cas_win, drv_win;

  always_comb begin
    act       = (phase_i == PH_ACT);
    col_phase = act && (cnt_i >= C_COL);
    cas_win   = act && (cnt_i >= C_CAS) && (cnt_i < C_END);
    drv_win   = col_phase && (cnt_i <= C_END);
    ras_n     = !act;
    ma        = col_phase ? MA_W'(col_i) : MA_W'(row_i);
    we_n      = !(we_i && col_phase && (cnt_i < C_END));
    oe_n      = !(!we_i && cas_win);
    dq_oe     = we_i && drv_win;
    done      = (phase_i == PH_PRE) && (cnt_i == '0);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cas_n[g] = !(cas_win && be_i[g]);
  end
endmodule

// File: rtl/edo_rd_capture.sv
module edo_rd_capture #(
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_i,
  input  logic [LANES-1:0] be_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int LW = DW / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        rdata_o[g*LW +: LW] <= '0;
      end else if (cap_i) begin
        rdata_o[g*LW +: LW] <= be_i[g] ? dq_i[g*LW +: LW] : '0;
      end
    end
  end
endmodule

// File: rtl/edo_cycle_gen.sv
module edo_cycle_gen
  import edo_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int COL_W = 9,
  parameter int DW    = 16,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RP  = 2,
  parameter int T_RAC = 5,
  parameter int T_CAC = 2,
  parameter int T_AA  = 3
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   req_i,
  input  logic                                   we_i,
  input  logic [ROW_W+COL_W-1:0]                 addr_i,
  input  logic [DW/8-1:0]                        be_i,
  input  logic [DW-1:0]                          wdata_i,
  output logic [DW-1:0]                          rdata_o,
  output logic                                   done_o,
  input  logic                                   grant_i,
  output logic                                   ras_n_o,
  output logic [DW/8-1:0]                        cas_n_o,
  output logic                                   we_n_o,
  output logic                                   oe_n_o,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] ma_o,
  output logic [DW-1:0]                          dq_o,
  output logic                                   dq_oe_o,
  input  logic [DW-1:0]                          dq_i
);
  localparam int LANES    = DW / 8;
  localparam int MA_W     = imax(ROW_W, COL_W);
  localparam int K_COL    = 1;
  localparam int K_CAS    = T_RCD;
  localparam int K_CAP    = imax(T_RAC, imax(K_CAS + T_CAC, K_COL + T_AA));
  localparam int K_CASEND = imax(K_CAS + T_CAS, K_CAP + 1);
  localparam int K_RASEND = K_CASEND + 1;
  localparam int CW       = $clog2(imax(K_RASEND, T_RP) + 1);

  phase_e           phase_q, phase_nxt;
  logic [CW-1:0]    cnt_q, cnt_nxt;
  logic             accept;
  logic             we_q;
  logic [LANES-1:0] be_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             op_we;
  logic [LANES-1:0] op_be;
  logic [ROW_W-1:0] op_row;
  logic [COL_W-1:0] op_col;
  logic             d_ras_n, d_we_n, d_oe_n, d_dq_oe, d_done;
  logic [LANES-1:0] d_cas_n;
  logic [MA_W-1:0]  d_ma;
  logic             cap;

  assign accept = (phase_q == PH_IDLE) && req_i && grant_i;

  edo_seq_timer #(
    .K_RASEND(K_RASEND),
    .T_RP    (T_RP),
    .CW      (CW)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start_i  (accept),
    .phase_q  (phase_q),
    .cnt_q    (cnt_q),
    .phase_nxt(phase_nxt),
    .cnt_nxt  (cnt_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q  <= 1'b0;
      be_q  <= '0;
      row_q <= '0;
      col_q <= '0;
      dq_o  <= '0;
    end else if (accept) begin
      we_q  <= we_i;
      be_q  <= be_i;
      row_q <= addr_i[ROW_W+COL_W-1:COL_W];
      col_q <= addr_i[COL_W-1:0];
      dq_o  <= wdata_i;
    end
  end

  always_comb begin
    if (phase_q == PH_IDLE) begin
      op_we  = we_i;
      op_be  = be_i;
      op_row = addr_i[ROW_W+COL_W-1:COL_W];
      op_col = addr_i[COL_W-1:0];
    end else begin
      op_we  = we_q;
      op_be  = be_q;
      op_row = row_q;
      op_col = col_q;
    end
  end

  edo_strobe_dec #(
    .ROW_W   (ROW_W),
    .COL_W   (COL_W),
    .MA_W    (MA_W),
    .LANES   (LANES),
    .CW      (CW),
    .K_COL   (K_COL),
    .K_CAS   (K_CAS),
    .K_CASEND(K_CASEND)
  ) u_dec (
    .phase_i(phase_nxt),
    .cnt_i  (cnt_nxt),
    .we_i   (op_we),
    .be_i   (op_be),
    .row_i  (op_row),
    .col_i  (op_col),
    .ras_n  (d_ras_n),
    .cas_n  (d_cas_n),
    .we_n   (d_we_n),
    .oe_n   (d_oe_n),
    .ma     (d_ma),
    .dq_oe  (d_dq_oe),
    .done   (d_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_n_o <= 1'b1;
      cas_n_o <= '1;
      we_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      ma_o    <= '0;
      dq_oe_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      ras_n_o <= d_ras_n;
      cas_n_o <= d_cas_n;
      we_n_o  <= d_we_n;
      oe_n_o  <= d_oe_n;
      ma_o    <= d_ma;
      dq_oe_o <= d_dq_oe;
      done_o  <= d_done;
    end
  end

  assign cap = (phase_q == PH_ACT) && (cnt_q == CW'(K_CAP)) && !we_q;

  edo_rd_capture #(
    .DW   (DW),
    .LANES(LANES)
  ) u_cap (
    .clk    (clk),
    .rst    (rst),
    .cap_i  (cap),
    .be_i   (be_q),
    .dq_i   (dq_i),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/edo_cycle_gen_chk.sv
module edo_cycle_gen_chk #(
  parameter int LANES = 2,
  parameter int T_CAS = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_i,
  input logic             grant_i,
  input logic             ras_n_o,
  input logic [LANES-1:0] cas_n_o,
  input logic             we_n_o,
  input logic             oe_n_o,
  input logic             dq_oe_o,
  input logic             done_o
);
  logic any_cas_lo;
  assign any_cas_lo = (cas_n_o != '1);

  p_start_grant_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n_o) |-> ($past(grant_i, 2) && $past(req_i, 2)));

  p_cas_high_at_ras_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n_o) |-> (cas_n_o == '1));

  p_cas_inside_ras_r4: assert property (@(posedge clk) disable iff (rst)
    any_cas_lo |-> !ras_n_o);

  p_we_setup_r5: assert property (@(posedge clk) disable iff (rst)
    (any_cas_lo && !$past(any_cas_lo) && !we_n_o) |-> $past(!we_n_o));

  p_we_release_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n_o) |-> !any_cas_lo);

  p_oe_off_write_r5: assert property (@(posedge clk) disable iff (rst)
    !we_n_o |-> oe_n_o);

  p_drv_covers_write_r10: assert property (@(posedge clk) disable iff (rst)
    (any_cas_lo && !we_n_o) |-> dq_oe_o);

  p_drv_no_oe_r10: assert property (@(posedge clk) disable iff (rst)
    dq_oe_o |-> oe_n_o);

  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  for (genvar g = 0; g < LANES; g++) begin : g_width
    logic [7:0] low_cnt;
    always_ff @(posedge clk) begin
      if (rst || cas_n_o[g]) low_cnt <= '0;
      else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 8'd1;
    end
    p_cas_width_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(cas_n_o[g]) |-> (low_cnt >= 8'(T_CAS)));
  end
endmodule

bind edo_cycle_gen edo_cycle_gen_chk #(
  .LANES(DW/8),
  .T_CAS(T_CAS)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .req_i  (req_i),
  .grant_i(grant_i),
  .ras_n_o(ras_n_o),
  .cas_n_o(cas_n_o),
  .we_n_o (we_n_o),
  .oe_n_o (oe_n_o),
  .dq_oe_o(dq_oe_o),
  .done_o (done_o)
);

// File: tb/edo_cycle_gen_tb.sv
module edo_cycle_gen_tb;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, T_RAC = 5, T_CAC = 2, T_AA = 3;
  localparam int K_COL = 1;
  localparam int K_CAP0 = (T_RCD + T_CAC > K_COL + T_AA) ? T_RCD + T_CAC : K_COL + T_AA;
  localparam int K_CAP = (T_RAC > K_CAP0) ? T_RAC : K_CAP0;
  localparam int K_CE = (T_RCD + T_CAS > K_CAP + 1) ? T_RCD + T_CAS : K_CAP + 1;

  logic clk = 0, rst = 1;
  logic req_i = 0, we_i = 0, grant_i = 1;
  logic [17:0] addr_i = '0;
  logic [1:0] be_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o, dq_o;
  logic [15:0] dq_i = 16'hDEAD;
  logic done_o, ras_n_o, we_n_o, oe_n_o, dq_oe_o;
  logic [1:0] cas_n_o;
  logic [8:0] ma_o;

  always #4 clk = ~clk;

  edo_cycle_gen #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RAC(T_RAC),
                  .T_CAC(T_CAC), .T_AA(T_AA)) u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .be_i(be_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o), .grant_i(grant_i),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o),
    .ma_o(ma_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct { bit we; logic [15:0] exp; } item_t;
  item_t sb[$];
  logic [15:0] ref_mem [int];
  logic [15:0] dram [int];

  bit cur_we;
  logic [17:0] cur_addr;
  logic [1:0] cur_be;
  logic [15:0] cur_wdata;

  task automatic issue(input bit w, input logic [17:0] a, input logic [1:0] b, input logic [15:0] d);
    item_t it;
    logic [15:0] old;
    old = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    it.we = w;
    it.exp = {b[1] ? old[15:8] : 8'h00, b[0] ? old[7:0] : 8'h00};
    if (w) ref_mem[int'(a)] = {b[1] ? d[15:8] : old[15:8], b[0] ? d[7:0] : old[7:0]};
    sb.push_back(it);
    cur_we = w; cur_addr = a; cur_be = b; cur_wdata = d;
    we_i = w; addr_i = a; be_i = b; wdata_i = d; req_i = 1;
    @(negedge clk);
    while (!done_o) @(negedge clk);
    req_i = 0;
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (sb.size() == 0) chk(0, "R11 done without request", 1, 0);
      else begin
        item_t it;
        it = sb.pop_front();
        if (!it.we) chk(rdata_o == it.exp, "R8 read data", rdata_o, it.exp);
      end
    end
  end

  // strobe monitor and DRAM model
  int k, casf, colk, gap, low_len, oe_cnt;
  logic [8:0] row_l, col_l;
  logic prev_ras, prev_we, prev_done;
  logic [1:0] prev_cas, lanes_seen, fell, rose;

  always @(negedge clk) begin
    if (rst) begin
      prev_ras = 1; prev_cas = 2'b11; prev_we = 1; prev_done = 0;
      gap = 1000; k = 0; casf = -1; colk = -1; low_len = 0; oe_cnt = 0; lanes_seen = 0;
      row_l = '0; col_l = '0; dq_i = 16'hDEAD;
    end else begin
      if (!prev_ras && ras_n_o) begin
        chk(done_o, "R11 done with RAS rise", done_o, 1);
        chk(cas_n_o == 2'b11, "R4 CAS high at RAS rise", cas_n_o, 3);
        gap = 0;
      end
      if (ras_n_o) gap++;
      if (prev_ras && !ras_n_o) begin
        chk(cas_n_o == 2'b11, "R4 CAS high at RAS fall", cas_n_o, 3);
        chk(ma_o == cur_addr[17:9], "R3 row address", ma_o, cur_addr[17:9]);
        chk(gap >= T_RP, "R11 precharge gap", gap, T_RP);
        k = 0; casf = -1; colk = -1; row_l = ma_o; lanes_seen = 0; oe_cnt = 0; low_len = 0;
      end else if (!ras_n_o) k++;
      if (!ras_n_o && colk < 0 && k > 0 && ma_o != row_l) colk = k;
      fell = prev_cas & ~cas_n_o;
      rose = ~prev_cas & cas_n_o;
      if (fell != 0) begin
        if (lanes_seen == 0) begin
          chk(k == T_RCD, "R3 RAS-to-CAS delay", k, T_RCD);
          chk(ma_o == cur_addr[8:0], "R3 column address", ma_o, cur_addr[8:0]);
          casf = k; col_l = ma_o;
          if (colk < 0) colk = k;
          if (cur_we) begin
            chk(!prev_we && oe_n_o, "R5 early write strobes", {prev_we, oe_n_o}, 1);
            chk(dq_oe_o && dq_o == cur_wdata, "R10 write data driven", dq_o, cur_wdata);
          end else begin
            chk(!oe_n_o && we_n_o, "R6 read strobes", {oe_n_o, we_n_o}, 1);
          end
        end
        if (!we_n_o) begin
          int key;
          logic [15:0] w;
          key = int'({row_l, col_l});
          w = dram.exists(key) ? dram[key] : 16'h0000;
          if (fell[0]) w[7:0] = dq_o[7:0];
          if (fell[1]) w[15:8] = dq_o[15:8];
          dram[key] = w;
        end
        lanes_seen = lanes_seen | fell;
      end
      if (cas_n_o != 2'b11) low_len++;
      if (rose != 0)
        chk(low_len == K_CE - T_RCD && low_len >= T_CAS, "R9 CAS low width", low_len, K_CE - T_RCD);
      if (dq_oe_o) oe_cnt++;
      if (done_o) begin
        chk(!prev_done, "R11 single done pulse", prev_done, 0);
        chk(lanes_seen == cur_be, "R7 lanes strobed", lanes_seen, cur_be);
        chk(oe_cnt == (cur_we ? K_CE - K_COL + 1 : 0), "R10 driver window", oe_cnt,
            cur_we ? K_CE - K_COL + 1 : 0);
      end
      begin
        bit valid;
        logic [15:0] w;
        int key;
        key = int'({row_l, col_l});
        w = dram.exists(key) ? dram[key] : 16'h0000;
        valid = !ras_n_o && !oe_n_o && casf >= 0 && colk >= 0 && k >= T_RAC &&
                (k - casf) >= T_CAC && (k - colk) >= T_AA;
        dq_i[7:0]  = (valid && !cas_n_o[0]) ? w[7:0]  : 8'hAD;
        dq_i[15:8] = (valid && !cas_n_o[1]) ? w[15:8] : 8'hDE;
      end
      prev_ras = ras_n_o; prev_cas = cas_n_o; prev_we = we_n_o; prev_done = done_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(ras_n_o && cas_n_o == 2'b11 && we_n_o && oe_n_o && !dq_oe_o && !done_o,
        "R1 reset state", {ras_n_o, cas_n_o, we_n_o, oe_n_o, dq_oe_o, done_o}, 6'b111110);
    rst = 0;
    @(negedge clk);
    chk(ras_n_o && cas_n_o == 2'b11 && !done_o, "R1 after reset", {ras_n_o, cas_n_o}, 7);

    // R2: grant withheld
    grant_i = 0;
    fork
      issue(1, 18'h12345, 2'b11, 16'hA5C3);
      begin
        bit bad = 0;
        repeat (20) @(negedge clk) if (!ras_n_o) bad = 1;
        chk(!bad, "R2 no cycle without grant", bad, 0);
        grant_i = 1;
      end
    join

    issue(0, 18'h12345, 2'b11, 16'h0);
    issue(0, 18'h12345, 2'b01, 16'h0);
    issue(0, 18'h12345, 2'b10, 16'h0);
    issue(0, 18'h12345, 2'b00, 16'h0);

    // R7 byte-lane merge
    issue(1, 18'h00F0F, 2'b11, 16'hAAAA);
    issue(1, 18'h00F0F, 2'b01, 16'h12FF);
    issue(0, 18'h00F0F, 2'b11, 16'h0);
    issue(1, 18'h00F0F, 2'b10, 16'h5577);
    issue(0, 18'h00F0F, 2'b11, 16'h0);
    issue(1, 18'h00F0F, 2'b00, 16'h9999);
    issue(0, 18'h00F0F, 2'b11, 16'h0);

    // row equal to column, and pattern sweep
    for (int i = 0; i < 8; i++)
      issue(1, {9'(i * 37 + 5), 9'(i * 37 + 5)}, 2'b11, 16'(i * 16'h1357 + 16'h0101));
    for (int i = 0; i < 8; i++)
      issue(0, {9'(i * 37 + 5), 9'(i * 37 + 5)}, 2'b11, 16'h0);
    for (int i = 0; i < 6; i++)
      issue(i % 2 == 0, {9'(i), 9'(511 - i)}, 2'(i % 4), 16'hC0DE ^ 16'(i));
    for (int i = 0; i < 6; i++)
      issue(0, {9'(i), 9'(511 - i)}, 2'b11, 16'h0);

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R11 all requests completed", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule